// File: doc/BRIEF.md
# CAN Controller Error and Status Register

This block holds the error and status word of a CAN controller. The protocol engine feeds it single-cycle event pulses: a frame was sent, a frame was received, a new last-error code is available, the message memory reported an ECC fault, or the bus woke the node from power-down. It also feeds two error counters, a bus-off level and a power-down acknowledge level. The block turns the counters into a warning flag (either counter at 96 or above) and a passive flag (either counter at 128 or above). It presents everything as one 32-bit word on `rd_data`. The word is always visible and is not gated by the read strobe.

Pulsing `rd_en` marks a software read of the word. That read has side effects on the following clock edge. The transmit-done, receive-done, wake-up and ECC flags clear, and the last-error code returns to 7, which means "no update since last read". While `dbg_halt` is high, a read has no side effects at all. An event that arrives in the same cycle as a clearing read takes priority over the read.

A single interrupt line is driven by a two-state request machine, `IRQ_IDLE` and `IRQ_PEND`. Transition `raise` (IDLE→PEND) fires on a qualifying event. The status group (transmit, receive, wake-up, error-code update) qualifies when `sts_ie` is set. The error group (ECC fault, rising bus-off, rising warning) qualifies when `err_ie` is set. Transition `hold` (PEND→PEND) applies while no clearing read occurs, or when a qualifying event coincides with a clearing read. Transition `drop` (PEND→IDLE) fires on a clearing read with no qualifying event in the same cycle. The passive flag never raises the interrupt.

Top module: `can_errstat`

## Requirements
- R1: After reset `rd_data` equals 32'h0000_0007 (error code 7, all other bits 0), and `irq` is 0.
- R2: Field positions are fixed. Bits 2:0 hold the error code, bit 3 transmit-done, bit 4 receive-done, bit 5 passive, bit 6 warning, bit 7 bus-off, bit 8 ECC fault, bit 9 wake-up pending and bit 10 power-down acknowledge. Bits 31:11 always read 0.
- R3: A pulse on `ev_tx_ok`, `ev_rx_ok` or `ev_wake` sets bit 3, 4 or 9 at the next edge. A clearing read clears these bits at the next edge, except for a bit whose event occurs in the same cycle, which stays set.
- R4: With `ev_lec_vld` high, `ev_lec` is loaded into bits 2:0 at the next edge. A clearing read loads 7 at the next edge, unless `ev_lec_vld` is high in the same cycle, in which case the event code is loaded.
- R5: `ecc_dbl` sets bit 8. `ecc_sgl` sets bit 8 only while `sec_off` is 1. A clearing read clears bit 8.
- R6: Bit 6 is 1 one clock after either `tec` or `rec` is 96 or more, and 0 one clock after both are below 96.
- R7: Bit 5 is 1 one clock after either counter is 128 or more. Bits 7 and 10 follow `bus_off` and `pd_ack` with one clock of delay. Reads do not affect bits 5, 6, 7 or 10.
- R8: While `dbg_halt` is 1, an `rd_en` pulse changes no bit and leaves `irq` unchanged.
- R9: With `sts_ie` set, a transmit, receive, wake-up or error-code event drives `irq` to 1 at the next edge.
- R10: With `err_ie` set, an ECC fault, a 0→1 change of bus-off or a 0→1 change of warning drives `irq` to 1 at the edge where the flag sets.
- R11: A change of the passive flag never raises `irq`, and events of a group whose enable is 0 do not raise it.
- R12: Once raised, `irq` stays 1 until a clearing read. It is 0 after that read's edge, unless a qualifying event occurs in the same cycle, in which case it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe; side effects apply at the next edge |
| dbg_halt | input | 1 | Debug halt; suppresses read side effects |
| rd_data | output | 32 | Register word |
| ev_tx_ok | input | 1 | Frame transmitted pulse |
| ev_rx_ok | input | 1 | Frame received pulse |
| ev_wake | input | 1 | Bus wake-up pulse |
| ev_lec_vld | input | 1 | Error code update strobe |
| ev_lec | input | 3 | Error code value |
| ecc_dbl | input | 1 | Double-bit memory error pulse |
| ecc_sgl | input | 1 | Single-bit memory error pulse |
| sec_off | input | 1 | Single-bit correction disabled |
| tec | input | CNT_W | Transmit error counter |
| rec | input | CNT_W | Receive error counter |
| bus_off | input | 1 | Bus-off level from the protocol engine |
| pd_ack | input | 1 | Power-down acknowledge level |
| sts_ie | input | 1 | Status-group interrupt enable |
| err_ie | input | 1 | Error-group interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Each counter is swept over every value from 0 to 255 while the other counter is held at 0. The expected warning and passive bits are computed from the thresholds, so the sweep separates an off-by-one at 95/96 or 127/128 from a wrong counter pairing. Each event type is pulsed alone, then together with a clearing read, then together with a debug-halted read. These three patterns separate a missing event priority from a missing debug suppression. The interrupt is driven by each status and error source with its enable on and off. A passive-only transition with `err_ie` set shows that the passive flag is excluded from the interrupt sources. A read coinciding with an event shows that the event takes priority when the request would otherwise drop.

// File: rtl/can_errstat_pkg.sv
package can_errstat_pkg;

    localparam logic [2:0] LEC_NONE = 3'd7;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ESR_W   = 11;

    typedef struct packed {
        logic       pd_ack;   // bit 10
        logic       wake;     // bit 9
        logic       ecc;      // bit 8
        logic       boff;     // bit 7
        logic       warn;     // bit 6
        logic       passive;  // bit 5
        logic       rx_ok;    // bit 4
        logic       tx_ok;    // bit 3
        logic [2:0] lec;      // bits 2:0
    } esr_t;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;

endpackage

// File: rtl/can_errstat_level.sv
module can_errstat_level #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned NUM_CNT  = 2,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input  logic                     boff_in,
    input  logic                     pd_in,
    output logic                     warn_q,
    output logic                     passive_q,
    output logic                     boff_q,
    output logic                     pd_q,
    output logic                     warn_rise,
    output logic                     boff_rise
);

    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);

    logic [NUM_CNT-1:0] over_warn;
    logic [NUM_CNT-1:0] over_pass;
    logic               warn_d;
    logic               pass_d;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [CNT_W-1:0] cval;
        assign cval         = cnt_flat[g*CNT_W +: CNT_W];
        assign over_warn[g] = (cval >= WARN_V);
        assign over_pass[g] = (cval >= PASS_V);
    end

    assign warn_d = |over_warn;
    assign pass_d = |over_pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_q    <= 1'b0;
            passive_q <= 1'b0;
            boff_q    <= 1'b0;
            pd_q      <= 1'b0;
        end else begin
            warn_q    <= warn_d;
            passive_q <= pass_d;
            boff_q    <= boff_in;
            pd_q      <= pd_in;
        end
    end

    assign warn_rise = warn_d & ~warn_q;
    assign boff_rise = boff_in & ~boff_q;

    // Passive threshold lies above the warning threshold (default configuration).
    assert_passive_implies_warn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        passive_q |-> warn_q);

    assert_warn_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warn_rise |=> warn_q);

endmodule

// File: rtl/can_errstat_flags.sv
module can_errstat_flags
    import can_errstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ev_tx,
    input  logic       ev_rx,
    input  logic       ev_wake,
    input  logic       ev_lec_vld,
    input  logic [2:0] ev_lec,
    input  logic       ecc_dbl,
    input  logic       ecc_sgl,
    input  logic       sec_off,
    output logic       tx_q,
    output logic       rx_q,
    output logic       wake_q,
    output logic       ecc_q,
    output logic [2:0] lec_q,
    output logic       ecc_set
);

    assign ecc_set = ecc_dbl | (ecc_sgl & sec_off);

    // Event has priority over a clearing read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= 1'b0;
            rx_q   <= 1'b0;
            wake_q <= 1'b0;
            ecc_q  <= 1'b0;
            lec_q  <= LEC_NONE;
        end else begin
            if (ev_tx)        tx_q   <= 1'b1;
            else if (clr)     tx_q   <= 1'b0;
            if (ev_rx)        rx_q   <= 1'b1;
            else if (clr)     rx_q   <= 1'b0;
            if (ev_wake)      wake_q <= 1'b1;
            else if (clr)     wake_q <= 1'b0;
            if (ecc_set)      ecc_q  <= 1'b1;
            else if (clr)     ecc_q  <= 1'b0;
            if (ev_lec_vld)   lec_q  <= ev_lec;
            else if (clr)     lec_q  <= LEC_NONE;
        end
    end

    assert_lec_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_lec_vld) |=> (lec_q == LEC_NONE));

    assert_tx_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx |=> tx_q);

    assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_rx) |=> !rx_q);

    assert_ecc_single_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_q && ecc_sgl && !sec_off && !ecc_dbl) |=> !ecc_q);

endmodule

// File: rtl/can_errstat_irq.sv
module can_errstat_irq
    import can_errstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sts_ie,
    input  logic err_ie,
    input  logic sts_ev,
    input  logic err_ev,
    input  logic clr,
    output logic irq
);

    irq_state_t state_q;
    irq_state_t state_d;
    logic       raise;

    assign raise = (sts_ie & sts_ev) | (err_ie & err_ev);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise)          state_d = IRQ_PEND;   // raise
            IRQ_PEND: if (clr && !raise)  state_d = IRQ_IDLE;   // drop, else hold
            default:                      state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end

    assert_raise_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clr && !raise) |=> !irq);

endmodule

// File: rtl/can_errstat.sv
module can_errstat
    import can_errstat_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned WARN_LIM = 96,
    parameter int unsigned PASS_LIM = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             dbg_halt,
    output logic [31:0]      rd_data,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_ok,
    input  logic             ev_wake,
    input  logic             ev_lec_vld,
    input  logic [2:0]       ev_lec,
    input  logic             ecc_dbl,
    input  logic             ecc_sgl,
    input  logic             sec_off,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             bus_off,
    input  logic             pd_ack,
    input  logic             sts_ie,
    input  logic             err_ie,
    output logic             irq
);

    localparam int unsigned NUM_CNT = 2;
    localparam int unsigned PAD_W   = WORD_W - ESR_W;

    esr_t esr;
    logic clr;
    logic ecc_set;
    logic warn_rise;
    logic boff_rise;
    logic sts_ev;
    logic err_ev;

    assign clr = rd_en & ~dbg_halt;

    can_errstat_level #(
        .CNT_W    (CNT_W),
        .NUM_CNT  (NUM_CNT),
        .WARN_LIM (WARN_LIM),
        .PASS_LIM (PASS_LIM)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_flat  ({rec, tec}),
        .boff_in   (bus_off),
        .pd_in     (pd_ack),
        .warn_q    (esr.warn),
        .passive_q (esr.passive),
        .boff_q    (esr.boff),
        .pd_q      (esr.pd_ack),
        .warn_rise (warn_rise),
        .boff_rise (boff_rise)
    );

    can_errstat_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .ev_tx      (ev_tx_ok),
        .ev_rx      (ev_rx_ok),
        .ev_wake    (ev_wake),
        .ev_lec_vld (ev_lec_vld),
        .ev_lec     (ev_lec),
        .ecc_dbl    (ecc_dbl),
        .ecc_sgl    (ecc_sgl),
        .sec_off    (sec_off),
        .tx_q       (esr.tx_ok),
        .rx_q       (esr.rx_ok),
        .wake_q     (esr.wake),
        .ecc_q      (esr.ecc),
        .lec_q      (esr.lec),
        .ecc_set    (ecc_set)
    );

    assign sts_ev = ev_tx_ok | ev_rx_ok | ev_wake | ev_lec_vld;
    assign err_ev = ecc_set | warn_rise | boff_rise;

    can_errstat_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sts_ie (sts_ie),
        .err_ie (err_ie),
        .sts_ev (sts_ev),
        .err_ev (err_ev),
        .clr    (clr),
        .irq    (irq)
    );

    assign rd_data = {{PAD_W{1'b0}}, esr};

    assert_dbg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dbg_halt && !sts_ev && !ecc_set)
        |=> ($stable(rd_data[4:0]) && $stable(rd_data[9:8])));

    assert_dbg_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dbg_halt && irq) |=> irq);

    assert_passive_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(sts_ie && sts_ev) && !(err_ie && err_ev)) |=> !irq);

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:11] == '0);

endmodule

// File: tb/sim_can_errstat.sv
`timescale 1ns/1ps
module sim_can_errstat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 0, dbg_halt = 0;
    logic [31:0] rd_data;
    logic        ev_tx_ok = 0, ev_rx_ok = 0, ev_wake = 0, ev_lec_vld = 0;
    logic [2:0]  ev_lec = 0;
    logic        ecc_dbl = 0, ecc_sgl = 0, sec_off = 0;
    logic [7:0]  tec = 0, rec = 0;
    logic        bus_off = 0, pd_ack = 0, sts_ie = 0, err_ie = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_errstat u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .dbg_halt(dbg_halt),
        .rd_data(rd_data), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_wake(ev_wake), .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec),
        .ecc_dbl(ecc_dbl), .ecc_sgl(ecc_sgl), .sec_off(sec_off),
        .tec(tec), .rec(rec), .bus_off(bus_off), .pd_ack(pd_ack),
        .sts_ie(sts_ie), .err_ie(err_ie), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read();
        rd_en = 1; tick(); rd_en = 0;
    endtask

    function automatic logic [31:0] lvl_word(input int t, input int r);
        logic w, p;
        w = (t >= 96) || (r >= 96);
        p = (t >= 128) || (r >= 128);
        return (32'(w) << 6) | (32'(p) << 5) | 32'h7;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset
        chk("R1 reset word", rd_data, 32'h7);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);

        // R2 / R7 power-down acknowledge at bit 10
        pd_ack = 1; tick();
        chk("R2 pd_ack bit10", rd_data, 32'h407);
        pd_ack = 0; tick();
        chk("R7 pd_ack follows", rd_data, 32'h7);

        // R6 / R7 counter sweeps
        for (int v = 0; v < 256; v++) begin
            tec = v[7:0]; tick();
            chk("R6 R7 tec sweep", rd_data, lvl_word(v, 0));
        end
        tec = 0;
        for (int v = 0; v < 256; v++) begin
            rec = v[7:0]; tick();
            chk("R6 R7 rec sweep", rd_data, lvl_word(0, v));
        end
        rec = 0; tick();
        chk("R6 counters below", rd_data, 32'h7);

        // R7 bus-off level, and reads do not touch level bits
        bus_off = 1; tec = 8'd130; tick();
        do_read();
        chk("R7 bus-off and levels kept over read", rd_data, 32'hE7);
        bus_off = 0; tec = 0; tick();
        chk("R7 bus-off follows", rd_data, 32'h7);

        // R3 event flags
        ev_tx_ok = 1; tick(); ev_tx_ok = 0;
        chk("R3 tx set", rd_data, 32'h0F);
        ev_rx_ok = 1; tick(); ev_rx_ok = 0;
        chk("R3 rx set", rd_data, 32'h1F);
        ev_wake = 1; tick(); ev_wake = 0;
        chk("R3 wake set", rd_data, 32'h21F);
        chk("R11 no irq with enables off", {31'b0, irq}, 32'h0);
        do_read();
        chk("R3 read clears", rd_data, 32'h7);
        ev_rx_ok = 1; rd_en = 1; tick(); ev_rx_ok = 0; rd_en = 0;
        chk("R3 event wins over read", rd_data, 32'h17);
        do_read();
        chk("R3 cleared after", rd_data, 32'h7);

        // R4 error code
        for (int c = 0; c < 7; c++) begin
            ev_lec_vld = 1; ev_lec = c[2:0]; tick(); ev_lec_vld = 0;
            chk("R4 code load", rd_data, 32'(c));
            do_read();
            chk("R4 read sets 7", rd_data, 32'h7);
        end
        ev_lec_vld = 1; ev_lec = 3'd3; rd_en = 1; tick(); ev_lec_vld = 0; rd_en = 0;
        chk("R4 event wins over read", rd_data, 32'h3);
        do_read();

        // R5 ECC
        ecc_sgl = 1; tick(); ecc_sgl = 0;
        chk("R5 single ignored", rd_data, 32'h7);
        sec_off = 1; ecc_sgl = 1; tick(); ecc_sgl = 0; sec_off = 0;
        chk("R5 single with correction off", rd_data, 32'h107);
        do_read();
        chk("R5 read clears", rd_data, 32'h7);
        ecc_dbl = 1; tick(); ecc_dbl = 0;
        chk("R5 double sets", rd_data, 32'h107);
        do_read();

        // R9 status interrupt sources
        sts_ie = 1;
        ev_tx_ok = 1; tick(); ev_tx_ok = 0;
        chk("R9 tx irq", {31'b0, irq}, 32'h1);
        do_read();
        chk("R12 read drops irq", {31'b0, irq}, 32'h0);
        ev_rx_ok = 1; tick(); ev_rx_ok = 0;
        chk("R9 rx irq", {31'b0, irq}, 32'h1);
        do_read();
        ev_wake = 1; tick(); ev_wake = 0;
        chk("R9 wake irq", {31'b0, irq}, 32'h1);
        do_read();
        ev_lec_vld = 1; ev_lec = 3'd5; tick(); ev_lec_vld = 0;
        chk("R9 lec irq", {31'b0, irq}, 32'h1);

        // R8 debug hold
        ev_tx_ok = 1; tick(); ev_tx_ok = 0;
        dbg_halt = 1; do_read();
        chk("R8 debug read keeps bits", rd_data, 32'h0D);
        chk("R8 debug read keeps irq", {31'b0, irq}, 32'h1);
        dbg_halt = 0;
        // R12 hold without read, then event beats read
        tick(); tick();
        chk("R12 hold", {31'b0, irq}, 32'h1);
        ev_tx_ok = 1; rd_en = 1; tick(); ev_tx_ok = 0; rd_en = 0;
        chk("R12 event keeps irq", {31'b0, irq}, 32'h1);
        do_read();
        chk("R12 plain read drops", {31'b0, irq}, 32'h0);
        chk("R8 later read clears", rd_data, 32'h7);
        sts_ie = 0;

        // R10 error interrupt sources
        err_ie = 1;
        ecc_dbl = 1; tick(); ecc_dbl = 0;
        chk("R10 ecc irq", {31'b0, irq}, 32'h1);
        do_read();
        chk("R10 ecc read drop", {31'b0, irq}, 32'h0);
        tec = 8'd100; tick();
        chk("R10 warn irq", {31'b0, irq}, 32'h1);
        do_read();
        chk("R10 warn read drop", {31'b0, irq}, 32'h0);
        // R11 passive change silent
        tec = 8'd130; tick(); tick();
        chk("R11 passive set", rd_data, 32'h67);
        chk("R11 passive no irq", {31'b0, irq}, 32'h0);
        tec = 8'd100; tick(); tick();
        chk("R11 passive clear no irq", {31'b0, irq}, 32'h0);
        tec = 0; tick();
        bus_off = 1; tick();
        chk("R10 bus-off irq", {31'b0, irq}, 32'h1);
        do_read();
        bus_off = 0; tick();
        err_ie = 0;
        bus_off = 1; tick();
        chk("R11 bus-off with enable off", {31'b0, irq}, 32'h0);
        bus_off = 0; tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule